// File: doc/BRIEF.md
# Hash Engine Command Sequencer

This block is the control state machine that sits between software commands and the datapath of a sponge-based hash engine. Software issues one command at a time through a one-hot command field: begin a message, finish absorbing, run one more permutation, finish the operation, or acknowledge an error. The sequencer turns these commands into level and pulse controls for the datapath: absorb enable, padding request, permutation request, state clear and flush.

The padding logic and the permutation are outside the block. Each is reached through a request that stays high until the datapath returns a one-cycle acknowledge. The sequencer reports idle and squeeze status and passes configuration writes through only while idle. It raises a done interrupt when absorption completes. It also raises a done interrupt when a software-owned operation has recovered from an error. An error input moves the block into a waiting state. Software then acknowledges the error, and the block flushes for a fixed number of cycles before it becomes idle again. Commands that the current state does not accept are dropped and flagged.

Top module: `hash_cmd_seq`

## Requirements
- R1: After reset, idle_o is 1, and all other outputs are 0 while no inputs are active.
- R2: cfg_wr_o follows cfg_wr_i while idle_o is 1 and is 0 in every other state.
- R3: A start command (cmd_i bit 0) in idle moves the block to absorbing in the following cycle: absorb_en_o is 1 and idle_o is 0.
- R4: A process command (cmd_i bit 1) while absorbing raises pad_req_o, which stays high until pad_ack_i. In the cycle after the acknowledge, squeeze_o is 1 and done_irq_o pulses for exactly one cycle.
- R5: A run command (cmd_i bit 2) while squeezing raises perm_req_o and drops squeeze_o until perm_ack_i. After the acknowledge, squeeze_o returns and done_irq_o stays 0.
- R6: A done command (cmd_i bit 3) while squeezing pulses clear_o for one cycle and returns the block to idle in the same cycle.
- R7: A single command that the current state does not accept leaves every status output unchanged and pulses seq_err_o for one cycle.
- R8: A cmd_i value with more than one bit set is ignored in every state and pulses seq_err_o.
- R9: err_i in any state other than error-wait or flush pulses err_irq_o and moves the block to error-wait. In error-wait, idle_o, absorb_en_o, pad_req_o, perm_req_o, squeeze_o and flush_o are all 0 until an error acknowledge (cmd_i bit 4) arrives.
- R10: The error acknowledge holds flush_o high for exactly FLUSH_CYCLES cycles, after which idle_o is 1.
- R11: When the flush ends, done_irq_o pulses together with idle_o if hw_app_i was 0 at the start command of the failed operation. If hw_app_i was 1, done_irq_o stays 0.
- R12: err_i takes priority over any command in the same cycle. That command is dropped without raising seq_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 5 | One-hot command: 0 start, 1 process, 2 run, 3 done, 4 error acknowledge |
| err_i | input | 1 | Error event from the datapath |
| pad_ack_i | input | 1 | Padding and absorption finished |
| perm_ack_i | input | 1 | Permutation finished |
| hw_app_i | input | 1 | Operation owned by a hardware requester (sampled at start) |
| cfg_wr_i | input | 1 | Configuration write request |
| cfg_wr_o | output | 1 | Configuration write, gated by idle |
| absorb_en_o | output | 1 | Message data accepted |
| pad_req_o | output | 1 | Padding request, held until acknowledge |
| perm_req_o | output | 1 | Single-permutation request, held until acknowledge |
| clear_o | output | 1 | One-cycle state clear pulse |
| flush_o | output | 1 | FIFO and state flush in progress |
| idle_o | output | 1 | Idle status |
| squeeze_o | output | 1 | Squeeze status, state readable |
| done_irq_o | output | 1 | Done interrupt pulse |
| err_irq_o | output | 1 | Error interrupt pulse |
| seq_err_o | output | 1 | Rejected command pulse |

## Verification
The bench targets the cases where a sequencer tends to go wrong. A run command issued while absorbing must be rejected. A design that accepted it would raise perm_req_o in the middle of a message. A manual permutation must not produce a done interrupt, because a spurious interrupt would make software read the state twice. An error arriving together with a process command must win. A design that let the command through would start padding on a faulty message or flag a sequencing error that never happened. The flush is counted cycle by cycle against FLUSH_CYCLES, and the final done interrupt is checked for both ownership settings. An off-by-one timer or a lost owner flag therefore shows up at the ports.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  localparam int CMD_W       = 5;
  localparam int CMD_START   = 0;
  localparam int CMD_PROCESS = 1;
  localparam int CMD_RUN     = 2;
  localparam int CMD_DONE    = 3;
  localparam int CMD_ERR_ACK = 4;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ABSORB   = 3'd1,
    ST_PAD      = 3'd2,
    ST_SQUEEZE  = 3'd3,
    ST_PERM     = 3'd4,
    ST_ERR_WAIT = 3'd5,
    ST_FLUSH    = 3'd6
  } seq_state_e;

  // Set of commands each state will act upon.
  function automatic logic [CMD_W-1:0] legal_cmds(seq_state_e st);
    logic [CMD_W-1:0] m;
    m = '0;
    case (st)
      ST_IDLE:     m[CMD_START]   = 1'b1;
      ST_ABSORB:   m[CMD_PROCESS] = 1'b1;
      ST_SQUEEZE: begin
        m[CMD_RUN]  = 1'b1;
        m[CMD_DONE] = 1'b1;
      end
      ST_ERR_WAIT: m[CMD_ERR_ACK] = 1'b1;
      default:     m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/hcs_rst_sync.sv
module hcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/hcs_cmd_decode.sv
module hcs_cmd_decode
  import hcs_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  input  seq_state_e       state_i,
  output logic [CMD_W-1:0] accept_o,
  output logic             reject_o
);

  logic             single_hot;
  logic [CMD_W-1:0] allowed;

  always_comb begin
    single_hot = $onehot(cmd_i);
    allowed    = legal_cmds(state_i);
  end

  for (genvar g = 0; g < CMD_W; g++) begin : g_accept
    assign accept_o[g] = single_hot & cmd_i[g] & allowed[g];
  end

  // Any non-zero command that produced no strobe is rejected.
  assign reject_o = (|cmd_i) & ~(|accept_o);

endmodule

// File: rtl/hcs_flush_timer.sv
module hcs_flush_timer #(
  parameter int FLUSH_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic last_o
);

  localparam int CW = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(FLUSH_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? LOAD_VAL : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = run_i & (cnt_q == '0);

endmodule

// File: rtl/hcs_fsm.sv
module hcs_fsm
  import hcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] accept_i,
  input  logic             reject_i,
  input  logic             err_i,
  input  logic             pad_ack_i,
  input  logic             perm_ack_i,
  input  logic             flush_last_i,
  input  logic             owner_hw_i,
  output seq_state_e       state_o,
  output logic             flush_load_o,
  output logic             done_irq_o,
  output logic             err_irq_o,
  output logic             seq_err_o,
  output logic             clear_o
);

  seq_state_e state_q, state_d;
  logic       done_d, err_d, seq_d, clr_d, load_d;
  logic       in_recovery, take_err;

  always_comb begin
    state_d     = state_q;
    done_d      = 1'b0;
    err_d       = 1'b0;
    clr_d       = 1'b0;
    load_d      = 1'b0;
    in_recovery = (state_q == ST_ERR_WAIT) || (state_q == ST_FLUSH);
    take_err    = err_i && !in_recovery;
    // An error drops any command of the same cycle silently.
    seq_d       = reject_i && !take_err;

    if (take_err) begin
      state_d = ST_ERR_WAIT;
      err_d   = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_i[CMD_START]) state_d = ST_ABSORB;
        end
        ST_ABSORB: begin
          if (accept_i[CMD_PROCESS]) state_d = ST_PAD;
        end
        ST_PAD: begin
          if (pad_ack_i) begin
            state_d = ST_SQUEEZE;
            done_d  = 1'b1;
          end
        end
        ST_SQUEEZE: begin
          if (accept_i[CMD_RUN]) begin
            state_d = ST_PERM;
          end else if (accept_i[CMD_DONE]) begin
            state_d = ST_IDLE;
            clr_d   = 1'b1;
          end
        end
        ST_PERM: begin
          if (perm_ack_i) state_d = ST_SQUEEZE;
        end
        ST_ERR_WAIT: begin
          if (accept_i[CMD_ERR_ACK]) begin
            state_d = ST_FLUSH;
            load_d  = 1'b1;
          end
        end
        ST_FLUSH: begin
          if (flush_last_i) begin
            state_d = ST_IDLE;
            done_d  = !owner_hw_i;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      done_irq_o <= 1'b0;
      err_irq_o  <= 1'b0;
      seq_err_o  <= 1'b0;
      clear_o    <= 1'b0;
    end else begin
      state_q    <= state_d;
      done_irq_o <= done_d;
      err_irq_o  <= err_d;
      seq_err_o  <= seq_d;
      clear_o    <= clr_d;
    end
  end

  assign state_o      = state_q;
  assign flush_load_o = load_d;

endmodule

// File: rtl/hash_cmd_seq.sv
module hash_cmd_seq
  import hcs_pkg::*;
#(
  parameter int FLUSH_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [4:0] cmd_i,
  input  logic       err_i,
  input  logic       pad_ack_i,
  input  logic       perm_ack_i,
  input  logic       hw_app_i,
  input  logic       cfg_wr_i,
  output logic       cfg_wr_o,
  output logic       absorb_en_o,
  output logic       pad_req_o,
  output logic       perm_req_o,
  output logic       clear_o,
  output logic       flush_o,
  output logic       idle_o,
  output logic       squeeze_o,
  output logic       done_irq_o,
  output logic       err_irq_o,
  output logic       seq_err_o
);

  logic             rst_n;
  logic [CMD_W-1:0] accept;
  logic             reject;
  seq_state_e       state;
  logic             flush_load, flush_last;
  logic             owner_q, owner_d, owner_en;

  hcs_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  hcs_cmd_decode u_dec (
    .cmd_i    (cmd_i),
    .state_i  (state),
    .accept_o (accept),
    .reject_o (reject)
  );

  hcs_flush_timer #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (flush_load),
    .run_i  (flush_o),
    .last_o (flush_last)
  );

  hcs_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .accept_i     (accept),
    .reject_i     (reject),
    .err_i        (err_i),
    .pad_ack_i    (pad_ack_i),
    .perm_ack_i   (perm_ack_i),
    .flush_last_i (flush_last),
    .owner_hw_i   (owner_q),
    .state_o      (state),
    .flush_load_o (flush_load),
    .done_irq_o   (done_irq_o),
    .err_irq_o    (err_irq_o),
    .seq_err_o    (seq_err_o),
    .clear_o      (clear_o)
  );

  // Owner of the running operation: captured at start, dropped in idle.
  always_comb begin
    owner_en = accept[CMD_START] | idle_o;
    owner_d  = accept[CMD_START] ? hw_app_i : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= 1'b0;
    end else if (owner_en) begin
      owner_q <= owner_d;
    end
  end

  always_comb begin
    idle_o      = (state == ST_IDLE);
    absorb_en_o = (state == ST_ABSORB);
    pad_req_o   = (state == ST_PAD);
    squeeze_o   = (state == ST_SQUEEZE);
    perm_req_o  = (state == ST_PERM);
    flush_o     = (state == ST_FLUSH);
    cfg_wr_o    = cfg_wr_i & idle_o;
  end

endmodule

// File: rtl/hcs_checker.sv
module hcs_checker #(
  parameter int FLUSH_CYCLES = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic err_i,
  input logic pad_ack_i,
  input logic perm_ack_i,
  input logic idle_o,
  input logic absorb_en_o,
  input logic pad_req_o,
  input logic perm_req_o,
  input logic squeeze_o,
  input logic flush_o,
  input logic clear_o,
  input logic done_irq_o,
  input logic err_irq_o,
  input logic seq_err_o
);

  int unsigned fl_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_cnt <= 0;
    end else if (flush_o) begin
      fl_cnt <= fl_cnt + 1;
    end else begin
      fl_cnt <= 0;
    end
  end

  // R4: padding request is held until acknowledged
  p_pad_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_req_o && !pad_ack_i && !err_i) |=> pad_req_o);

  // R5: a finished manual permutation brings squeeze back without an interrupt
  p_run_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perm_req_o && perm_ack_i && !err_i) |=> (squeeze_o && !done_irq_o));

  // R6: the clear pulse coincides with idle
  p_clear_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> idle_o);

  // R7: a rejected command leaves the status unchanged
  p_reject_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> $stable({idle_o, absorb_en_o, pad_req_o, perm_req_o, squeeze_o, flush_o}));

  // R9: at most one status output at a time
  p_status_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idle_o, absorb_en_o, pad_req_o, perm_req_o, squeeze_o, flush_o}));

  // R9: an error outside recovery raises the error interrupt and leaves idle
  p_err_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && (idle_o || absorb_en_o || pad_req_o || perm_req_o || squeeze_o))
      |=> (err_irq_o && !idle_o));

  // R10: flush lasts exactly the configured number of cycles
  p_flush_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_o) |-> (fl_cnt == FLUSH_CYCLES));

  // R10: the flush always ends in idle
  p_flush_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_o) |-> idle_o);

endmodule

bind hash_cmd_seq hcs_checker #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .err_i       (err_i),
  .pad_ack_i   (pad_ack_i),
  .perm_ack_i  (perm_ack_i),
  .idle_o      (idle_o),
  .absorb_en_o (absorb_en_o),
  .pad_req_o   (pad_req_o),
  .perm_req_o  (perm_req_o),
  .squeeze_o   (squeeze_o),
  .flush_o     (flush_o),
  .clear_o     (clear_o),
  .done_irq_o  (done_irq_o),
  .err_irq_o   (err_irq_o),
  .seq_err_o   (seq_err_o)
);

// File: tb/test_hash_cmd_seq.sv
`timescale 1ns/1ps
module test_hash_cmd_seq;

  localparam int FL_N = 4;
  localparam int S_IDLE = 0, S_ABS = 1, S_PAD = 2, S_RUN = 3, S_SQZ = 4, S_WAIT = 5, S_FL = 6;
  localparam logic [4:0] C_NONE = 5'b00000, C_START = 5'b00001, C_PROC = 5'b00010,
                         C_RUN = 5'b00100, C_DONE = 5'b01000, C_ACK = 5'b10000;

  logic clk, rst_n;
  logic [4:0] cmd;
  logic err, pad_ack, perm_ack, hw_app, cfg_wr;
  logic cfg_wr_o, absorb_en, pad_req, perm_req, clear, flush, idle, squeeze;
  logic done_irq, err_irq, seq_err;

  int total, bad, cycles;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  hash_cmd_seq #(.FLUSH_CYCLES(FL_N)) i_hash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .err_i(err), .pad_ack_i(pad_ack),
    .perm_ack_i(perm_ack), .hw_app_i(hw_app), .cfg_wr_i(cfg_wr), .cfg_wr_o(cfg_wr_o),
    .absorb_en_o(absorb_en), .pad_req_o(pad_req), .perm_req_o(perm_req), .clear_o(clear),
    .flush_o(flush), .idle_o(idle), .squeeze_o(squeeze), .done_irq_o(done_irq),
    .err_irq_o(err_irq), .seq_err_o(seq_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected port vector:
  // {idle, absorb, pad, perm, squeeze, flush, done_irq, err_irq, seq_err, clear, cfg_wr}
  function automatic logic [10:0] ev(int st, bit d, bit e, bit s, bit c, bit w);
    logic [5:0] stat;
    case (st)
      S_IDLE:  stat = 6'b100000;
      S_ABS:   stat = 6'b010000;
      S_PAD:   stat = 6'b001000;
      S_RUN:   stat = 6'b000100;
      S_SQZ:   stat = 6'b000010;
      S_FL:    stat = 6'b000001;
      default: stat = 6'b000000;
    endcase
    return {stat, d, e, s, c, w};
  endfunction

  // Driver: apply one cycle of stimulus and queue the result expected after the edge.
  task automatic step(input logic [4:0] c, input logic e, input logic pa, input logic ma,
                      input logic hw, input logic w, input logic [10:0] expv, input string tag);
    @(negedge clk);
    cmd = c; err = e; pad_ack = pa; perm_ack = ma; hw_app = hw; cfg_wr = w;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare after each edge, away from it.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [10:0] got, want;
      string t;
      want = exp_q.pop_front();
      t    = tag_q.pop_front();
      got  = {idle, absorb_en, pad_req, perm_req, squeeze, flush,
              done_irq, err_irq, seq_err, clear, cfg_wr_o};
      total++;
      if (got !== want) begin
        bad++;
        $display("FAIL %s: got %b expected %b", t, got, want);
      end
    end
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    total = 0; bad = 0;
    cmd = C_NONE; err = 0; pad_ack = 0; perm_ack = 0; hw_app = 0; cfg_wr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state
    step(C_NONE, 0, 0, 0, 0, 0, ev(S_IDLE, 0, 0, 0, 0, 0), "R1 reset");
    // R2 configuration passes in idle
    step(C_NONE, 0, 0, 0, 0, 1, ev(S_IDLE, 0, 0, 0, 0, 1), "R2 cfg idle");
    // R7 process in idle rejected
    step(C_PROC, 0, 0, 0, 0, 0, ev(S_IDLE, 0, 0, 1, 0, 0), "R7 process in idle");
    // R3 start
    step(C_START, 0, 0, 0, 0, 0, ev(S_ABS, 0, 0, 0, 0, 0), "R3 start");
    // R2 configuration blocked while absorbing
    step(C_NONE, 0, 0, 0, 0, 1, ev(S_ABS, 0, 0, 0, 0, 0), "R2 cfg blocked");
    // R7 run while absorbing
    step(C_RUN, 0, 0, 0, 0, 0, ev(S_ABS, 0, 0, 1, 0, 0), "R7 run in absorb");
    // R8 multi-hot
    step(C_START | C_PROC, 0, 0, 0, 0, 0, ev(S_ABS, 0, 0, 1, 0, 0), "R8 multi-hot");
    // R4 process, hold, acknowledge
    step(C_PROC, 0, 0, 0, 0, 0, ev(S_PAD, 0, 0, 0, 0, 0), "R4 pad req");
    step(C_NONE, 0, 0, 0, 0, 0, ev(S_PAD, 0, 0, 0, 0, 0), "R4 pad hold");
    step(C_NONE, 0, 1, 0, 0, 0, ev(S_SQZ, 1, 0, 0, 0, 0), "R4 done irq");
    step(C_NONE, 0, 0, 0, 0, 0, ev(S_SQZ, 0, 0, 0, 0, 0), "R4 irq one cycle");
    // R5 manual permutation
    step(C_RUN, 0, 0, 0, 0, 0, ev(S_RUN, 0, 0, 0, 0, 0), "R5 run");
    step(C_NONE, 0, 0, 0, 0, 0, ev(S_RUN, 0, 0, 0, 0, 0), "R5 run hold");
    step(C_NONE, 0, 0, 1, 0, 0, ev(S_SQZ, 0, 0, 0, 0, 0), "R5 no irq");
    // R6 done
    step(C_DONE, 0, 0, 0, 0, 0, ev(S_IDLE, 0, 0, 0, 1, 0), "R6 clear");
    step(C_NONE, 0, 0, 0, 0, 0, ev(S_IDLE, 0, 0, 0, 0, 0), "R6 clear one cycle");

    // Software-owned error path
    step(C_START, 0, 0, 0, 0, 0, ev(S_ABS, 0, 0, 0, 0, 0), "R3 start sw");
    step(C_PROC, 1, 0, 0, 0, 0, ev(S_WAIT, 0, 1, 0, 0, 0), "R12 err beats process");
    step(C_NONE, 0, 0, 0, 0, 0, ev(S_WAIT, 0, 0, 0, 0, 0), "R9 wait");
    step(C_START, 0, 0, 0, 0, 0, ev(S_WAIT, 0, 0, 1, 0, 0), "R7 start in wait");
    step(C_ACK, 0, 0, 0, 0, 0, ev(S_FL, 0, 0, 0, 0, 0), "R10 flush 1");
    for (int i = 1; i < FL_N; i++)
      step(C_NONE, 0, 0, 0, 0, 0, ev(S_FL, 0, 0, 0, 0, 0), "R10 flush hold");
    step(C_NONE, 0, 0, 0, 0, 0, ev(S_IDLE, 1, 0, 0, 0, 0), "R11 done irq sw");

    // Hardware-owned error path
    step(C_START, 0, 0, 0, 1, 0, ev(S_ABS, 0, 0, 0, 0, 0), "R3 start hw");
    step(C_PROC, 0, 0, 0, 0, 0, ev(S_PAD, 0, 0, 0, 0, 0), "R4 pad hw");
    step(C_NONE, 1, 0, 0, 0, 0, ev(S_WAIT, 0, 1, 0, 0, 0), "R9 err in pad");
    step(C_ACK, 0, 0, 0, 0, 0, ev(S_FL, 0, 0, 0, 0, 0), "R10 flush hw");
    for (int i = 1; i < FL_N; i++)
      step(C_NONE, 0, 0, 0, 0, 0, ev(S_FL, 0, 0, 0, 0, 0), "R10 flush hw hold");
    step(C_NONE, 0, 0, 0, 0, 0, ev(S_IDLE, 0, 0, 0, 0, 0), "R11 no irq hw");

    // Error from idle, then recovery again
    step(C_NONE, 1, 0, 0, 0, 0, ev(S_WAIT, 0, 1, 0, 0, 0), "R9 err in idle");
    step(C_ACK, 0, 0, 0, 0, 0, ev(S_FL, 0, 0, 0, 0, 0), "R10 flush idle-err");
    for (int i = 1; i < FL_N; i++)
      step(C_NONE, 0, 0, 0, 0, 0, ev(S_FL, 0, 0, 0, 0, 0), "R10 flush idle-err hold");
    step(C_NONE, 0, 0, 0, 0, 0, ev(S_IDLE, 1, 0, 0, 0, 0), "R11 done irq idle-err");

    @(negedge clk);
    cmd = C_NONE;
    repeat (3) @(posedge clk);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule